// File: doc/BRIEF.md
# Power-On Strap Latch and Frequency Selector

This block decides which frequency code a clock generator runs at. A small set of pins has two jobs. While power-on reset is held, the block reads their levels as a 5-bit configuration strap. When reset is released it freezes that value. One cycle later it enables the pin drivers, so the same pins can carry clock outputs. From then on the strap is never sampled again.

A control byte written over the configuration bus picks the code that takes effect. When its source bit is clear, the frozen strap sets the code. When the bit is set, a 5-bit software code set by the same byte is used instead. The same byte also turns on spread-spectrum modulation and can float every output. A bus write only updates a shadow copy of the byte. The shadow is copied to the live copy on a separate commit strobe, so a write in progress never changes the running frequency. The frozen strap is also output as-is for readback.

Top module: `strap_freq_sel`

## Requirements
- R1: While `por_n` is low, every rising clock edge loads `strap_pin_i` into the strap register. `sel_code_o` and `strap_rb_o` then show that value, because the control byte is zero during reset.
- R2: The strap register closes at the last rising edge at which `por_n` is low. After that, changes on `strap_pin_i` never alter `strap_rb_o` or a strap-selected `sel_code_o` until the next reset.
- R3: `pin_oe_o` is low while `por_n` is low and during the first cycle after release. It goes high at the second rising edge with `por_n` high (`OE_DELAY` = 1), unless the tristate bit is set.
- R4: A write (`ctl_wr_i` high) stores `ctl_wdata_i` in the shadow byte only. `sel_code_o`, `spread_en_o`, `tristate_o` and `pin_oe_o` are unaffected until a commit.
- R5: At a rising edge with `ctl_commit_i` high, the live byte takes the shadow value held before that edge, and the outputs change right after that edge. If a write and a commit fall in the same cycle, the commit takes the older shadow and the new data stays waiting in the shadow.
- R6: Bit 3 of the live byte selects the source: 0 selects the strap, 1 selects the software code. The software code is bit 2 as code bit 4, with bits 7:4 as code bits 3:0.
- R7: Bit 1 of the live byte drives `spread_en_o`. Bit 0 drives `tristate_o`, and while bit 0 is set `pin_oe_o` is low.
- R8: Reset clears both the shadow and the live byte. After every reset the strap sets the code, with spread off and outputs not tristated.
- R9: `strap_rb_o` shows the frozen strap in both source modes, whatever has been written or committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low; asserts asynchronously |
| strap_pin_i | input | 5 | Levels on the shared strap/clock pins |
| ctl_wr_i | input | 1 | Bus write strobe for the control byte shadow |
| ctl_wdata_i | input | 8 | Control byte data |
| ctl_commit_i | input | 1 | Copies the shadow byte into the live byte |
| sel_code_o | output | 5 | Active frequency select code |
| spread_en_o | output | 1 | Spread-spectrum enable |
| tristate_o | output | 1 | Float-all-outputs request |
| pin_oe_o | output | 1 | Output-driver enable for the shared pins |
| strap_rb_o | output | 5 | Frozen strap value for readback |

## Verification
While reset is held, a pin level applied before an edge is due in `sel_code_o` and `strap_rb_o` just after that edge. `pin_oe_o` is due at the second edge after reset release. A committed byte is due at the outputs one edge after the commit, and a write alone is due nowhere. The bench drives inputs 1 ns after a rising edge and samples 1 ns after the next one. It updates a shadow/live model on the same edge the design does, so every comparison is made in the cycle a result is due. Directed cases cover the release edge, pin changes after freezing, and a write that coincides with a commit. Random write/commit/pin traffic is then compared cycle by cycle.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  localparam int SEL_W      = 5;
  localparam int CTL_W      = 8;
  localparam int SRC_BIT    = 3;
  localparam int SPREAD_BIT = 1;
  localparam int TRI_BIT    = 0;
  localparam int SWHI_BIT   = 2;

  typedef struct packed {
    logic             sw_src;
    logic             spread;
    logic             tri_all;
    logic [SEL_W-1:0] sw_code;
  } ctl_t;

  // Field extraction of the control byte; code bit 4 comes from byte bit 2.
  function automatic ctl_t decode_ctl(input logic [CTL_W-1:0] b);
    ctl_t c;
    c.sw_src  = b[SRC_BIT];
    c.spread  = b[SPREAD_BIT];
    c.tri_all = b[TRI_BIT];
    c.sw_code = {b[SWHI_BIT], b[7:4]};
    return c;
  endfunction
endpackage

// File: rtl/sfs_strap_latch.sv
module sfs_strap_latch #(
  parameter int SEL_W    = 5,
  parameter int OE_DELAY = 1
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic [SEL_W-1:0] pins_i,
  output logic [SEL_W-1:0] strap_o,
  output logic             closed_o,
  output logic             oe_seq_o
);
  localparam int CNT_W = (OE_DELAY < 2) ? 1 : $clog2(OE_DELAY + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OE_DELAY - 1);

  logic [SEL_W-1:0] strap_q;
  logic             closed_q;
  logic             oe_q;
  logic [CNT_W-1:0] wait_cnt;
  logic             latch_close;

  // Transparent while reset is held, frozen afterwards.
  always_ff @(posedge clk) begin
    if (!por_n) strap_q <= pins_i;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      closed_q <= 1'b0;
      oe_q     <= 1'b0;
      wait_cnt <= '0;
    end else begin
      closed_q <= 1'b1;
      if (closed_q && !oe_q) begin
        if (wait_cnt == CNT_LAST) oe_q <= 1'b1;
        else                      wait_cnt <= wait_cnt + 1'b1;
      end
    end
  end

  assign latch_close = por_n && !closed_q;
  assign strap_o     = strap_q;
  assign closed_o    = closed_q;
  assign oe_seq_o    = oe_q;

  // R2: once closed the strap never moves
  p_strap_frozen_r2: assert property (@(posedge clk) disable iff (!por_n)
    closed_q |=> $stable(strap_q));
  // R3: drivers come on only after the latch has closed
  p_oe_after_close_r3: assert property (@(posedge clk) disable iff (!por_n)
    oe_q |-> closed_q);
  // R3: the closing cycle itself never has drivers on
  p_no_oe_at_close_r3: assert property (@(posedge clk) disable iff (!por_n)
    latch_close |-> !oe_q);
endmodule

// File: rtl/sfs_ctl_regs.sv
module sfs_ctl_regs #(
  parameter int CTL_W = 8
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             wr_i,
  input  logic [CTL_W-1:0] wdata_i,
  input  logic             commit_i,
  output logic [CTL_W-1:0] live_o
);
  logic [CTL_W-1:0] shadow_q;
  logic [CTL_W-1:0] live_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      shadow_q <= '0;
      live_q   <= '0;
    end else begin
      if (wr_i)     shadow_q <= wdata_i;
      if (commit_i) live_q   <= shadow_q;
    end
  end

  assign live_o = live_q;

  // R4: without a commit the live byte holds
  p_live_hold_r4: assert property (@(posedge clk) disable iff (!por_n)
    !commit_i |=> $stable(live_q));
  // R5: a commit takes the shadow as it stood before the edge
  p_commit_copy_r5: assert property (@(posedge clk) disable iff (!por_n)
    commit_i |=> (live_q == $past(shadow_q)));
endmodule

// File: rtl/sfs_freq_select.sv
module sfs_freq_select
  import sfs_pkg::*;
(
  input  logic             clk,
  input  logic             por_n,
  input  logic [CTL_W-1:0] live_i,
  input  logic [SEL_W-1:0] strap_i,
  input  logic             oe_seq_i,
  output logic [SEL_W-1:0] sel_o,
  output logic             spread_o,
  output logic             tri_o,
  output logic             oe_o
);
  ctl_t ctl;

  always_comb begin
    ctl      = decode_ctl(live_i);
    sel_o    = ctl.sw_src ? ctl.sw_code : strap_i;
    spread_o = ctl.spread;
    tri_o    = ctl.tri_all;
    oe_o     = oe_seq_i && !ctl.tri_all;
  end

  // R7: a floated block never drives its pins
  p_tri_blocks_oe_r7: assert property (@(posedge clk) disable iff (!por_n)
    tri_o |-> !oe_o);
endmodule

// File: rtl/strap_freq_sel.sv
module strap_freq_sel
  import sfs_pkg::*;
#(
  parameter int OE_DELAY = 1
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic [4:0]       strap_pin_i,
  input  logic             ctl_wr_i,
  input  logic [7:0]       ctl_wdata_i,
  input  logic             ctl_commit_i,
  output logic [4:0]       sel_code_o,
  output logic             spread_en_o,
  output logic             tristate_o,
  output logic             pin_oe_o,
  output logic [4:0]       strap_rb_o
);
  logic [SEL_W-1:0] strap_w;
  logic             closed_w;
  logic             oe_seq_w;
  logic [CTL_W-1:0] live_w;

  sfs_strap_latch #(.SEL_W(SEL_W), .OE_DELAY(OE_DELAY)) u_latch (
    .clk      (clk),
    .por_n    (por_n),
    .pins_i   (strap_pin_i),
    .strap_o  (strap_w),
    .closed_o (closed_w),
    .oe_seq_o (oe_seq_w)
  );

  sfs_ctl_regs #(.CTL_W(CTL_W)) u_ctl (
    .clk      (clk),
    .por_n    (por_n),
    .wr_i     (ctl_wr_i),
    .wdata_i  (ctl_wdata_i),
    .commit_i (ctl_commit_i),
    .live_o   (live_w)
  );

  sfs_freq_select u_sel (
    .clk      (clk),
    .por_n    (por_n),
    .live_i   (live_w),
    .strap_i  (strap_w),
    .oe_seq_i (oe_seq_w),
    .sel_o    (sel_code_o),
    .spread_o (spread_en_o),
    .tri_o    (tristate_o),
    .oe_o     (pin_oe_o)
  );

  assign strap_rb_o = strap_w;

  // R9: readback follows the frozen strap, not the live pins
  p_rb_frozen_r9: assert property (@(posedge clk) disable iff (!por_n)
    closed_w |=> $stable(strap_rb_o));
  // R3: pins are never driven before the strap freezes
  p_oe_needs_freeze_r3: assert property (@(posedge clk) disable iff (!por_n)
    pin_oe_o |-> closed_w);
endmodule

// File: tb/strap_freq_sel_test.sv
module strap_freq_sel_test;
  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic [4:0] strap_pin_i = '0;
  logic       ctl_wr_i = 1'b0;
  logic [7:0] ctl_wdata_i = '0;
  logic       ctl_commit_i = 1'b0;
  logic [4:0] sel_code_o;
  logic       spread_en_o, tristate_o, pin_oe_o;
  logic [4:0] strap_rb_o;

  int n_tests = 0;
  int n_fail  = 0;

  // bench model
  logic [7:0] m_shadow, m_live;
  logic [4:0] m_strap;
  logic       m_oe;

  strap_freq_sel uut (
    .clk(clk), .por_n(por_n), .strap_pin_i(strap_pin_i),
    .ctl_wr_i(ctl_wr_i), .ctl_wdata_i(ctl_wdata_i), .ctl_commit_i(ctl_commit_i),
    .sel_code_o(sel_code_o), .spread_en_o(spread_en_o), .tristate_o(tristate_o),
    .pin_oe_o(pin_oe_o), .strap_rb_o(strap_rb_o)
  );

  always #4 clk = ~clk;

  function automatic logic [4:0] want_sel(input logic [7:0] live, input logic [4:0] st);
    logic [4:0] sw;
    sw = {live[2], live[7], live[6], live[5], live[4]};
    return live[3] ? sw : st;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(input string req);
    check({req, " sel"}, {3'b0, sel_code_o}, {3'b0, want_sel(m_live, m_strap)});
    check({req, " spread"}, {7'b0, spread_en_o}, {7'b0, m_live[1]});
    check({req, " tri"}, {7'b0, tristate_o}, {7'b0, m_live[0]});
    check({req, " oe"}, {7'b0, pin_oe_o}, {7'b0, m_oe & ~m_live[0]});
    check({req, " rb"}, {3'b0, strap_rb_o}, {3'b0, m_strap});
  endtask

  // one clock edge; model updated as the design is; sample 1 ns after
  task automatic step();
    @(posedge clk);
    if (!por_n) m_strap = strap_pin_i;
    if (ctl_commit_i) m_live = m_shadow;
    if (ctl_wr_i) m_shadow = ctl_wdata_i;
    #1;
  endtask

  task automatic do_reset(input logic [4:0] pins);
    por_n = 1'b0; strap_pin_i = pins;
    ctl_wr_i = 0; ctl_commit_i = 0;
    #1;
    m_shadow = '0; m_live = '0; m_oe = 1'b0;
    repeat (3) step();
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    @(posedge clk); #1;
    do_reset(5'b10110);
    // R1, R8: reset state, strap tracked
    check_all("R1 reset");
    check("R3 oe in reset", {7'b0, pin_oe_o}, 8'h00);
    strap_pin_i = 5'b01011;
    step();
    check("R1 strap tracks pins in reset", {3'b0, sel_code_o}, 8'h0b);
    // release
    por_n = 1'b1;
    step();
    check("R3 oe low first cycle", {7'b0, pin_oe_o}, 8'h00);
    strap_pin_i = 5'b11111;
    step();
    m_oe = 1'b1;
    check("R3 oe high second edge", {7'b0, pin_oe_o}, 8'h01);
    check("R2 strap frozen", {3'b0, strap_rb_o}, 8'h0b);
    check("R8 strap selects by default", {3'b0, sel_code_o}, 8'h0b);
    // R4: write without commit
    ctl_wr_i = 1; ctl_wdata_i = 8'h5A;
    step();
    ctl_wr_i = 0;
    step();
    check("R4 write alone no effect sel", {3'b0, sel_code_o}, 8'h0b);
    check("R4 write alone no effect spread", {7'b0, spread_en_o}, 8'h00);
    // R5, R6: commit 0x5A -> sw code 00101, spread on
    ctl_commit_i = 1;
    step();
    ctl_commit_i = 0;
    check("R6 sw code", {3'b0, sel_code_o}, 8'h05);
    check("R7 spread on", {7'b0, spread_en_o}, 8'h01);
    // R5: write and commit together -> old shadow committed
    ctl_wr_i = 1; ctl_wdata_i = 8'h0D; ctl_commit_i = 1;
    step();
    ctl_wr_i = 0; ctl_commit_i = 0;
    check("R5 same-cycle commit keeps older shadow", {3'b0, sel_code_o}, 8'h05);
    check("R5 same-cycle tri unchanged", {7'b0, tristate_o}, 8'h00);
    ctl_commit_i = 1;
    step();
    ctl_commit_i = 0;
    check("R6 code bit4 from byte bit2", {3'b0, sel_code_o}, 8'h10);
    check("R7 tristate set", {7'b0, tristate_o}, 8'h01);
    check("R7 tristate kills oe", {7'b0, pin_oe_o}, 8'h00);
    check("R9 rb in sw mode", {3'b0, strap_rb_o}, 8'h0b);
    check_all("R7 directed");
    // random traffic
    for (int i = 0; i < 400; i++) begin
      ctl_wr_i     = ($urandom % 3) == 0;
      ctl_wdata_i  = 8'($urandom);
      ctl_commit_i = ($urandom % 4) == 0;
      strap_pin_i  = 5'($urandom);
      step();
      check_all("R2 R4 R5 R6 R7 R9 random");
    end
    // second reset with new straps: R8 defaults restored
    ctl_wr_i = 0; ctl_commit_i = 0;
    do_reset(5'b00111);
    por_n = 1'b1;
    step();
    strap_pin_i = 5'b11000;
    step();
    m_oe = 1'b1;
    check_all("R8 after second reset");
    check("R8 strap after second reset", {3'b0, sel_code_o}, 8'h07);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule